// File: doc/BRIEF.md
# Half-Bridge Gate Command Monitor with Overcurrent Latch

This block sits between the four logic-level gate commands that a controller produces (power-factor stage, half-bridge low side, half-bridge high side, filament heater) and the matching gate-driver enables. It gates every command with a global driver enable that the mode controller supplies. When the drivers are not enabled, nothing reaches a gate.

The block also protects the half-bridge in two ways. A cross-conduction interlock removes both half-bridge gates for as long as both half-bridge commands are high together. An overcurrent fault latch is set by a current-sense comparator flag, but only while the mode controller reports the operating state. Once set, the latch removes both half-bridge gates and raises a fault pin. The latch is released when the controller drives both half-bridge commands low in the same cycle and the comparator is no longer tripped. It is also released when the supply falls through undervoltage lockout. The power-factor and heater gates are not affected by the latch or the interlock.

All gate outputs and the fault pin are combinational from the inputs and a single latch flop. A new trip therefore blanks the half-bridge in the same cycle that the flag arrives.

Top module: `hb_input_monitor`

## Requirements
- R1: While `drv_en` is 0, all four gate outputs are 0, whatever the command inputs are.
- R2: While `drv_en` is 1, `gate_pfc` equals `cmd_pfc` and `gate_heat` equals `cmd_heat` in the same cycle, whether or not a fault is active and whether or not the half-bridge commands conflict.
- R3: While `cmd_low` and `cmd_high` are both 1, `gate_low` and `gate_high` are both 0.
- R4: While `drv_en` is 1, no fault is active, and only one half-bridge command is high, that command's gate output follows it in the same cycle.
- R5: When `oc_trip` is 1 while `op_mode` is 1 and `uvlo` is 0, `fault_out` goes to 1 and both half-bridge gates go to 0 in that same cycle. From the next clock edge the latch is held.
- R6: While `op_mode` is 0, `oc_trip` is ignored. It neither sets the latch nor raises `fault_out`, and the half-bridge gates keep following their commands.
- R7: Once set, the latch keeps `fault_out` at 1 and the half-bridge gates at 0 until a cycle in which `cmd_low` and `cmd_high` are both 0 and `oc_trip` is 0. The release takes effect from the following clock edge. A single half-bridge command going low does not release the latch.
- R8: A cycle in which both half-bridge commands are 0 does not release the latch while `oc_trip` is still 1.
- R9: A cycle with `uvlo` at 1 releases the latch from the following clock edge, and `oc_trip` is not accepted during that cycle.
- R10: After synchronous reset `rst`, the latch is clear. In the operating state with no trip, `fault_out` is therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_en | input | 1 | Global driver enable from the mode controller |
| op_mode | input | 1 | High while the mode controller is in the operating state |
| uvlo | input | 1 | Supply undervoltage lockout event |
| cmd_pfc | input | 1 | Power-factor stage gate command |
| cmd_low | input | 1 | Half-bridge low-side gate command |
| cmd_high | input | 1 | Half-bridge high-side gate command |
| cmd_heat | input | 1 | Filament heater gate command |
| oc_trip | input | 1 | Current-sense comparator flag |
| gate_pfc | output | 1 | Power-factor driver enable |
| gate_low | output | 1 | Low-side driver enable |
| gate_high | output | 1 | High-side driver enable |
| gate_heat | output | 1 | Heater driver enable |
| fault_out | output | 1 | Overcurrent fault indication |

## Verification
Every output is due in the same cycle that its inputs are applied, because the only register is the fault latch. The bench drives inputs at the falling edge and compares all five outputs one time unit later against a behavioural model.

A change of latch state takes effect only from the next rising edge. The model therefore updates its latch bit after that edge, and the bench checks release and hold behaviour in the cycle after the clearing stimulus. Directed sequences cover each set, hold and release corner. A random phase then mixes enable, mode, trip and undervoltage patterns.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

    // Four gate command / enable channels carried as one bundle.
    typedef struct packed {
        logic pfc;
        logic lo;
        logic hi;
        logic heat;
    } hbm_chan_t;

    // Action of the overcurrent latch for one cycle.
    typedef enum logic [1:0] {
        LATCH_KEEP  = 2'd0,
        LATCH_SET   = 2'd1,
        LATCH_CLEAR = 2'd2
    } hbm_latch_op_e;

    // Both half-bridge commands high: cross-conduction hazard.
    function automatic logic hb_conflict(input hbm_chan_t c);
        return c.lo & c.hi;
    endfunction

    // Both half-bridge commands low: release window.
    function automatic logic hb_idle(input hbm_chan_t c);
        return ~c.lo & ~c.hi;
    endfunction

    // Undervoltage wins, then a qualified trip, then release.
    function automatic hbm_latch_op_e latch_decide(
        input logic op_mode,
        input logic uvlo,
        input logic trip,
        input logic idle
    );
        if (uvlo)
            return LATCH_CLEAR;
        else if (op_mode && trip)
            return LATCH_SET;
        else if (idle && !trip)
            return LATCH_CLEAR;
        else
            return LATCH_KEEP;
    endfunction

endpackage

// File: rtl/hbm_fault_latch.sv
module hbm_fault_latch
    import hbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_mode,
    input  logic       uvlo,
    input  logic       oc_trip,
    input  hbm_chan_t  cmd,
    output logic       fault_active
);

    logic          latch_q;
    hbm_latch_op_e act;

    always_comb begin
        act = latch_decide(op_mode, uvlo, oc_trip, hb_idle(cmd));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
        end else begin
            unique case (act)
                LATCH_SET:   latch_q <= 1'b1;
                LATCH_CLEAR: latch_q <= 1'b0;
                default:     latch_q <= latch_q;
            endcase
        end
    end

    // A fresh trip acts in its own cycle; the flop holds it afterwards.
    always_comb begin
        fault_active = latch_q | (act == LATCH_SET);
    end

    p_trip_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (op_mode && oc_trip && !uvlo) |=> latch_q);

    p_uvlo_clears_r9: assert property (@(posedge clk) disable iff (rst)
        uvlo |=> !latch_q);

    p_hold_until_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !uvlo && !(cmd.lo == 1'b0 && cmd.hi == 1'b0 && !oc_trip)) |=> latch_q);

    p_no_set_outside_op_r6: assert property (@(posedge clk) disable iff (rst)
        (!latch_q && !op_mode) |=> !latch_q);

    p_trip_blocks_release_r8: assert property (@(posedge clk) disable iff (rst)
        (latch_q && oc_trip && !uvlo) |=> latch_q);

endmodule

// File: rtl/hbm_gate_mux.sv
module hbm_gate_mux
    import hbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       drv_en,
    input  logic       fault_active,
    input  hbm_chan_t  cmd,
    output hbm_chan_t  gate
);

    logic hb_allow;

    always_comb begin
        hb_allow  = drv_en & ~hb_conflict(cmd) & ~fault_active;
        gate.pfc  = drv_en & cmd.pfc;
        gate.heat = drv_en & cmd.heat;
        gate.lo   = hb_allow & cmd.lo;
        gate.hi   = hb_allow & cmd.hi;
    end

    p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (gate == '0));

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        !(gate.lo && gate.hi));

    p_fault_blanks_hb_r5: assert property (@(posedge clk) disable iff (rst)
        fault_active |-> (!gate.lo && !gate.hi));

    p_aux_follow_r2: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (gate.pfc == cmd.pfc && gate.heat == cmd.heat));

endmodule

// File: rtl/hb_input_monitor.sv
module hb_input_monitor
    import hbm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic drv_en,
    input  logic op_mode,
    input  logic uvlo,
    input  logic cmd_pfc,
    input  logic cmd_low,
    input  logic cmd_high,
    input  logic cmd_heat,
    input  logic oc_trip,
    output logic gate_pfc,
    output logic gate_low,
    output logic gate_high,
    output logic gate_heat,
    output logic fault_out
);

    hbm_chan_t cmd_b;
    hbm_chan_t gate_b;
    logic      fault_active;

    always_comb begin
        cmd_b.pfc  = cmd_pfc;
        cmd_b.lo   = cmd_low;
        cmd_b.hi   = cmd_high;
        cmd_b.heat = cmd_heat;
    end

    hbm_fault_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .op_mode      (op_mode),
        .uvlo         (uvlo),
        .oc_trip      (oc_trip),
        .cmd          (cmd_b),
        .fault_active (fault_active)
    );

    hbm_gate_mux u_mux (
        .clk          (clk),
        .rst          (rst),
        .drv_en       (drv_en),
        .fault_active (fault_active),
        .cmd          (cmd_b),
        .gate         (gate_b)
    );

    assign gate_pfc  = gate_b.pfc;
    assign gate_low  = gate_b.lo;
    assign gate_high = gate_b.hi;
    assign gate_heat = gate_b.heat;
    assign fault_out = fault_active;

    p_fault_low_when_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && op_mode && !oc_trip) |-> !fault_out);

endmodule

// File: tb/hb_input_monitor_tb_top.sv
`timescale 1ns/1ps
module hb_input_monitor_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drv_en = 0, op_mode = 0, uvlo = 0;
    logic cmd_pfc = 0, cmd_low = 0, cmd_high = 0, cmd_heat = 0, oc_trip = 0;
    logic gate_pfc, gate_low, gate_high, gate_heat, fault_out;

    int total = 0;
    int bad   = 0;
    bit ref_latch = 0;

    always #4 clk = ~clk;

    hb_input_monitor dut_i (
        .clk(clk), .rst(rst), .drv_en(drv_en), .op_mode(op_mode), .uvlo(uvlo),
        .cmd_pfc(cmd_pfc), .cmd_low(cmd_low), .cmd_high(cmd_high),
        .cmd_heat(cmd_heat), .oc_trip(oc_trip),
        .gate_pfc(gate_pfc), .gate_low(gate_low), .gate_high(gate_high),
        .gate_heat(gate_heat), .fault_out(fault_out)
    );

    task automatic chk(input string tag, input string name, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%b exp=%b t=%0t", tag, name, got, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, compare against the model, then advance it.
    task automatic step(input string tag, input bit r, input bit en, input bit op,
                        input bit uv, input bit pf, input bit lo, input bit hi,
                        input bit ht, input bit oc);
        bit trip_now, flt, pass_hb;
        @(negedge clk);
        rst = r; drv_en = en; op_mode = op; uvlo = uv;
        cmd_pfc = pf; cmd_low = lo; cmd_high = hi; cmd_heat = ht; oc_trip = oc;
        #1;
        trip_now = op && oc && !uv;
        flt      = ref_latch || trip_now;
        pass_hb  = en && !(lo && hi) && !flt;
        chk(tag, "gate_pfc",  gate_pfc,  en && pf);
        chk(tag, "gate_heat", gate_heat, en && ht);
        chk(tag, "gate_low",  gate_low,  pass_hb && lo);
        chk(tag, "gate_high", gate_high, pass_hb && hi);
        chk(tag, "fault_out", fault_out, flt);
        @(posedge clk);
        if (r)                   ref_latch = 0;
        else if (uv)             ref_latch = 0;
        else if (trip_now)       ref_latch = 1;
        else if (!lo && !hi && !oc) ref_latch = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog expired got=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state and clear latch afterwards
        step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R10", 0, 1, 1, 0, 0, 1, 0, 0, 0);
        // R1: disabled drivers block everything
        step("R1", 0, 0, 1, 0, 1, 1, 0, 1, 0);
        step("R1", 0, 0, 1, 0, 1, 0, 1, 1, 0);
        // R2 / R3: conflict blanks half-bridge only
        step("R3", 0, 1, 1, 0, 1, 1, 1, 1, 0);
        step("R2", 0, 1, 1, 0, 1, 1, 1, 0, 0);
        // R4: single commands pass
        step("R4", 0, 1, 1, 0, 0, 1, 0, 0, 0);
        step("R4", 0, 1, 1, 0, 0, 0, 1, 1, 0);
        // R6: trip outside operating mode ignored
        step("R6", 0, 1, 0, 0, 0, 1, 0, 0, 1);
        step("R6", 0, 1, 1, 0, 0, 1, 0, 0, 0);
        // R5: trip in operating mode sets in same cycle
        step("R5", 0, 1, 1, 0, 1, 1, 0, 1, 1);
        // R7: hold through single-side lows, release on both low
        step("R7", 0, 1, 1, 0, 1, 0, 1, 0, 0);
        step("R7", 0, 1, 1, 0, 0, 1, 0, 1, 0);
        step("R7", 0, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R7", 0, 1, 1, 0, 0, 1, 0, 0, 0);
        // R8: both low but trip still present keeps the latch
        step("R8", 0, 1, 1, 0, 0, 0, 1, 0, 1);
        step("R8", 0, 1, 1, 0, 0, 0, 0, 0, 1);
        step("R8", 0, 1, 1, 0, 0, 0, 1, 0, 0);
        step("R8", 0, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 1, 1, 0, 0, 0, 1, 0, 0);
        // R9: undervoltage releases, trip during it not accepted
        step("R9", 0, 1, 1, 0, 0, 1, 0, 0, 1);
        step("R9", 0, 0, 1, 1, 0, 1, 0, 0, 1);
        step("R9", 0, 1, 1, 0, 0, 1, 0, 0, 0);
        // Mixed random patterns
        for (int i = 0; i < 400; i++) begin
            logic [8:0] v;
            v = 9'($urandom);
            step("R2", 0, v[0] | v[8], v[1], (v[2] & v[3] & v[7]), v[4], v[5],
                 v[6], v[7], (v[3] & v[8]));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule